// File: doc/BRIEF.md
# I2C Bit-Clock Prescaler

This block derives the serial clock timing of an I2C controller from the system clock. It does not use one wide divider. It chains four short counting stages: a half-period counter that counts (T+1) system cycles, a power-of-two stage that counts 2^E of those, a multiplier stage that counts (K+1) of those, and a fixed decade stage. The serial clock level flips each time the decade stage wraps. The level therefore changes every 10·(T+1)·2^E·(K+1) system cycles, which gives a 50% duty cycle.

The host loads the timing through two write strobes. One strobe carries the 8-bit half-period count T. The other carries a control byte that packs the multiplier K and the exponent E. Written values are held in shadow storage. They reach the counters only when the serial clock rises, which is the boundary between two full periods, so no period is ever shortened or stretched partway through. Besides the clock level, the block produces three one-cycle strobes for the byte engine: one marking each level change, one in the middle of each high phase for sampling SDA, and one in the middle of each low phase for changing SDA.

Top module: `i2c_bit_prescaler`

## Requirements
- R1: While reset is held and in the first cycle after it, `scl_level` is 1 and `scl_toggle`, `tick_sample` and `tick_drive` are 0. The active settings start at T=24, K=2, E=0, so the first half period lasts 750 cycles.
- R2: Each high phase and each low phase of `scl_level` lasts exactly 10·(T+1)·2^E·(K+1) system cycles, counted from one level change to the next.
- R3: In the control byte, K is bits 6:3 and E is bits 2:0. Bit 7 has no effect on the timing.
- R4: A written K of 0 or 1 is used as 2.
- R5: A written T below 5 is used as 5. Values 5 to 255 are used as written.
- R6: A new T, K or E value first applies to the high phase that begins at the next rising edge of `scl_level`. Any phase already under way when the write occurs completes with the old timing.
- R7: `tick_sample` pulses for exactly one cycle, once per high phase, exactly half a phase after the rising edge. It is never high while `scl_level` is low.
- R8: `tick_drive` pulses for exactly one cycle, once per low phase, exactly half a phase after the falling edge. It is never high while `scl_level` is high.
- R9: `scl_toggle` is high for exactly the one cycle in which `scl_level` holds a newly changed value, and at no other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| thp_wr | input | 1 | Write strobe for the half-period count |
| thp_wdata | input | 8 | Half-period count T |
| ctl_wr | input | 1 | Write strobe for the control byte |
| ctl_wdata | input | 8 | Control byte: K in bits 6:3, E in bits 2:0 |
| scl_level | output | 1 | Serial clock level, 50% duty |
| scl_toggle | output | 1 | One-cycle pulse in the first cycle of each new level |
| tick_sample | output | 1 | One-cycle pulse at the middle of each high phase |
| tick_drive | output | 1 | One-cycle pulse at the middle of each low phase |

## Verification
The assertions check every cycle that the two mid-phase ticks only appear in their own phase, never overlap and last one cycle. They also check that the toggle strobe coincides exactly with level changes, that the active settings change only on a rising serial-clock edge, and that they never go below their floors. Exact phase lengths, tick offsets within a phase, the field positions of the control byte, the clamping of small values, and the old timing persisting for the rest of the current period can only be shown by the bench. The bench does this by counting cycles between level changes across several settings.

// File: rtl/i2cpre_pkg.sv
// Package: shared constants for the I2C bit-clock prescaler.
// Holds reset defaults and lower limits of the timing settings.
package i2cpre_pkg;
    localparam int THP_DEFAULT = 24;
    localparam int MUL_DEFAULT = 2;
    localparam int EXP_DEFAULT = 0;
    localparam int THP_FLOOR   = 5;
    localparam int MUL_FLOOR   = 2;
    localparam int DECADE      = 10;
endpackage

// File: rtl/i2cpre_modcnt.sv
// Module: i2cpre_modcnt
// Modulo counter stage. When enabled it counts 0..limit and then wraps.
// wrap is a combinational pulse in the enabled cycle that ends the count.
// Assumes limit changes only while count is 0.
module i2cpre_modcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic [W-1:0] count,
    output logic         wrap
);
    logic at_limit;

    // Detect the terminal value of this stage.
    always_comb begin
        at_limit = (count == limit);
        wrap     = en && at_limit;
    end

    // Advance or wrap the stage count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (en) begin
            count <= at_limit ? '0 : count + W'(1);
        end
    end
endmodule

// File: rtl/i2cpre_settings.sv
// Module: i2cpre_settings
// Shadow and active timing settings. Writes clamp to the floors and land
// in shadow storage. The active copy is refreshed only on the load pulse,
// which the phase logic raises at a full serial-clock period boundary.
module i2cpre_settings #(
    parameter int THP_W = 8,
    parameter int MUL_W = 4,
    parameter int EXP_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   thp_wr,
    input  logic [THP_W-1:0]       thp_wdata,
    input  logic                   ctl_wr,
    input  logic [MUL_W+EXP_W:0]   ctl_wdata,
    input  logic                   load,
    output logic [THP_W-1:0]       act_thp,
    output logic [MUL_W-1:0]       act_mul,
    output logic [EXP_W-1:0]       act_exp
);
    import i2cpre_pkg::*;

    localparam logic [THP_W-1:0] THP_MIN = THP_W'(THP_FLOOR);
    localparam logic [MUL_W-1:0] MUL_MIN = MUL_W'(MUL_FLOOR);

    logic [THP_W-1:0] sh_thp;
    logic [MUL_W-1:0] sh_mul;
    logic [EXP_W-1:0] sh_exp;
    logic [MUL_W-1:0] wr_mul;
    logic [EXP_W-1:0] wr_exp;

    // Split the control byte into its fields; the top bit is unused.
    always_comb begin
        wr_mul = ctl_wdata[EXP_W +: MUL_W];
        wr_exp = ctl_wdata[EXP_W-1:0];
    end

    // Capture host writes into shadow storage with floors applied.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_thp <= THP_W'(THP_DEFAULT);
            sh_mul <= MUL_W'(MUL_DEFAULT);
            sh_exp <= EXP_W'(EXP_DEFAULT);
        end else begin
            if (thp_wr) begin
                sh_thp <= (thp_wdata < THP_MIN) ? THP_MIN : thp_wdata;
            end
            if (ctl_wr) begin
                sh_mul <= (wr_mul < MUL_MIN) ? MUL_MIN : wr_mul;
                sh_exp <= wr_exp;
            end
        end
    end

    // Move the shadow values to the counters at a period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_thp <= THP_W'(THP_DEFAULT);
            act_mul <= MUL_W'(MUL_DEFAULT);
            act_exp <= EXP_W'(EXP_DEFAULT);
        end else if (load) begin
            act_thp <= sh_thp;
            act_mul <= sh_mul;
            act_exp <= sh_exp;
        end
    end
endmodule

// File: rtl/i2cpre_phase.sv
// Module: i2cpre_phase
// Serial clock level and strobes. Flips the level when the decade stage
// wraps and marks the middle of each phase from the decade count. Raises
// load when a low phase ends, i.e. when a full period ends.
// Assumes DIV is even, so the middle falls on a stage boundary.
module i2cpre_phase #(
    parameter int DIV = 10,
    parameter int DW  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic [DW-1:0] dec_count,
    input  logic          dec_wrap,
    output logic          scl_q,
    output logic          toggle_q,
    output logic          sample_q,
    output logic          drive_q,
    output logic          load
);
    localparam logic [DW-1:0] MID_PRE = DW'(DIV / 2 - 1);

    logic mid;

    // Middle of a phase and the period boundary.
    always_comb begin
        mid  = step && (dec_count == MID_PRE);
        load = dec_wrap && !scl_q;
    end

    // Register the level and the one-cycle strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q    <= 1'b1;
            toggle_q <= 1'b0;
            sample_q <= 1'b0;
            drive_q  <= 1'b0;
        end else begin
            scl_q    <= dec_wrap ? !scl_q : scl_q;
            toggle_q <= dec_wrap;
            sample_q <= mid && scl_q;
            drive_q  <= mid && !scl_q;
        end
    end
endmodule

// File: rtl/i2c_bit_prescaler.sv
// Module: i2c_bit_prescaler
// Top of the three-stage I2C bit-clock prescaler followed by a fixed
// decade stage. Stage chain: (T+1) cycles, 2^E, (K+1), then DIV.
// Assumes settings come from the host bridge as write strobes.
module i2c_bit_prescaler #(
    parameter int THP_W = 8,
    parameter int MUL_W = 4,
    parameter int EXP_W = 3,
    parameter int DIV   = i2cpre_pkg::DECADE
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 thp_wr,
    input  logic [THP_W-1:0]     thp_wdata,
    input  logic                 ctl_wr,
    input  logic [MUL_W+EXP_W:0] ctl_wdata,
    output logic                 scl_level,
    output logic                 scl_toggle,
    output logic                 tick_sample,
    output logic                 tick_drive
);
    localparam int POW_W = (1 << EXP_W) - 1;
    localparam int DW    = $clog2(DIV);
    localparam int NSTG  = 4;
    localparam int CW    = (THP_W > POW_W) ? THP_W : POW_W;

    logic [THP_W-1:0] act_thp;
    logic [MUL_W-1:0] act_mul;
    logic [EXP_W-1:0] act_exp;
    logic             load;

    logic [NSTG:0]    stg_en;
    logic [CW-1:0]    stg_lim [NSTG];
    logic [CW-1:0]    stg_cnt [NSTG];

    i2cpre_settings #(.THP_W(THP_W), .MUL_W(MUL_W), .EXP_W(EXP_W)) u_set (
        .clk(clk), .rst_n(rst_n),
        .thp_wr(thp_wr), .thp_wdata(thp_wdata),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .load(load),
        .act_thp(act_thp), .act_mul(act_mul), .act_exp(act_exp)
    );

    // Per-stage terminal values from the active settings.
    always_comb begin
        stg_en[0]  = 1'b1;
        stg_lim[0] = CW'(act_thp);
        stg_lim[1] = CW'(POW_W'((32'd1 << act_exp) - 32'd1));
        stg_lim[2] = CW'(act_mul);
        stg_lim[3] = CW'(DIV - 1);
    end

    // Chain of modulo stages, each enabled by the previous wrap.
    for (genvar g = 0; g < NSTG; g++) begin : g_stage
        i2cpre_modcnt #(.W(CW)) u_cnt (
            .clk(clk), .rst_n(rst_n),
            .en(stg_en[g]), .limit(stg_lim[g]),
            .count(stg_cnt[g]), .wrap(stg_en[g+1])
        );
    end

    i2cpre_phase #(.DIV(DIV), .DW(DW)) u_phase (
        .clk(clk), .rst_n(rst_n),
        .step(stg_en[3]), .dec_count(DW'(stg_cnt[3])), .dec_wrap(stg_en[4]),
        .scl_q(scl_level), .toggle_q(scl_toggle),
        .sample_q(tick_sample), .drive_q(tick_drive),
        .load(load)
    );
endmodule

// File: rtl/i2cpre_checker.sv
// Module: i2cpre_checker
// Cycle-by-cycle properties of the prescaler outputs and active settings.
module i2cpre_checker #(
    parameter int THP_W = 8,
    parameter int MUL_W = 4,
    parameter int EXP_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_level,
    input logic             scl_toggle,
    input logic             tick_sample,
    input logic             tick_drive,
    input logic [THP_W-1:0] act_thp,
    input logic [MUL_W-1:0] act_mul,
    input logic [EXP_W-1:0] act_exp
);
    AST_SAMPLE_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        tick_sample |-> scl_level); // R7
    AST_SAMPLE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick_sample |=> !tick_sample); // R7
    AST_DRIVE_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        tick_drive |-> !scl_level); // R8
    AST_DRIVE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick_drive |=> !tick_drive); // R8
    AST_TOGGLE_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        scl_toggle |-> (scl_level != $past(scl_level))); // R9
    AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !scl_toggle |-> $stable(scl_level)); // R9
    AST_SETTINGS_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(scl_level) |-> ($stable(act_thp) && $stable(act_mul) && $stable(act_exp))); // R6
    AST_MUL_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        act_mul >= MUL_W'(2)); // R4
    AST_THP_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        act_thp >= THP_W'(5)); // R5
endmodule

bind i2c_bit_prescaler i2cpre_checker #(.THP_W(THP_W), .MUL_W(MUL_W), .EXP_W(EXP_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .scl_level(scl_level), .scl_toggle(scl_toggle),
    .tick_sample(tick_sample), .tick_drive(tick_drive),
    .act_thp(act_thp), .act_mul(act_mul), .act_exp(act_exp)
);

// File: tb/tb_i2c_bit_prescaler.sv
// Directed bench: measures each serial-clock phase in cycles and checks
// length, tick position and strobe counts against the requirement formula.
module tb_i2c_bit_prescaler;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       thp_wr = 1'b0;
    logic [7:0] thp_wdata = '0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic       scl_level, scl_toggle, tick_sample, tick_drive;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #10 clk = !clk;

    i2c_bit_prescaler dut (
        .clk(clk), .rst_n(rst_n),
        .thp_wr(thp_wr), .thp_wdata(thp_wdata),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .scl_level(scl_level), .scl_toggle(scl_toggle),
        .tick_sample(tick_sample), .tick_drive(tick_drive)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int half_len(input int t, input int k, input int e);
        return 10 * (t + 1) * (1 << e) * (k + 1);
    endfunction

    // Measure one phase from the last level change; optionally issue a write early in it.
    task automatic measure_half(input bit do_wr, input int thp, input int ctl,
                                input int exp_len, input bit exp_high, input string tag);
        int n = 0;
        int ns = 0, nd = 0, nt = 0, off = -1;
        bit lvl = scl_level;
        check(tag, "phase level", lvl, exp_high);
        while (1) begin
            @(negedge clk);
            n++;
            if (do_wr && n == 1) begin
                thp_wr = 1'b1; thp_wdata = 8'(thp);
                ctl_wr = 1'b1; ctl_wdata = 8'(ctl);
            end else begin
                thp_wr = 1'b0; ctl_wr = 1'b0;
            end
            if (tick_sample) begin ns++; off = n; end
            if (tick_drive)  begin nd++; off = n; end
            if (scl_toggle) nt++;
            if (scl_level != lvl) break;
            if (n > 60000) begin
                check(tag, "phase watchdog", n, exp_len);
                return;
            end
        end
        check(tag, "phase length", n, exp_len);
        check(exp_high ? "R7" : "R8", "tick offset", off, exp_len / 2);
        check("R7", "sample ticks in phase", ns, exp_high ? 1 : 0);
        check("R8", "drive ticks in phase", nd, exp_high ? 0 : 1);
        check("R9", "toggle strobe at change", scl_toggle, 1);
        check("R9", "toggle strobes in phase", nt, 1);
    endtask

    // Write during a low phase, then check old timing to the boundary and new after it.
    task automatic run_case(input int thp, input int ctl, input int old_len,
                            input int new_len, input string tag);
        measure_half(1'b1, thp, ctl, old_len, 1'b0, "R6");
        measure_half(1'b0, 0, 0, new_len, 1'b1, tag);
        measure_half(1'b0, 0, 0, new_len, 1'b0, tag);
        measure_half(1'b0, 0, 0, new_len, 1'b1, "R2");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1", "scl_level in reset", scl_level, 1);
        check("R1", "scl_toggle in reset", scl_toggle, 0);
        check("R1", "tick_sample in reset", tick_sample, 0);
        check("R1", "tick_drive in reset", tick_drive, 0);
        rst_n = 1'b1;
        // R1: default first phase, then a default low phase (750 cycles)
        measure_half(1'b0, 0, 0, half_len(24, 2, 0), 1'b1, "R1");
        // R2: T=5, K=2, E=0
        run_case(5, 8'h10, half_len(24, 2, 0), half_len(5, 2, 0), "R2");
        // R4: K=0 clamped to 2, E=1 in bits 2:0
        run_case(5, 8'h01, half_len(5, 2, 0), half_len(5, 2, 1), "R4");
        // R5: T=2 clamped to 5; R3: K=3, E=3
        run_case(2, 8'h1B, half_len(5, 2, 1), half_len(5, 3, 3), "R5");
        // R3: K=15 in bits 6:3, E=0, T=7
        run_case(7, 8'h78, half_len(5, 3, 3), half_len(7, 15, 0), "R3");
        // R4: K=1 clamped to 2, E=2
        run_case(5, 8'h0A, half_len(7, 15, 0), half_len(5, 2, 2), "R4");
        // R3: bit 7 set has no effect, K=2, E=0
        run_case(5, 8'h90, half_len(5, 2, 2), half_len(5, 2, 0), "R3");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule